// File: doc/BRIEF.md
# Trailing-Opcode Escape Instruction Decoder

This block sits in an instruction front end and takes instruction bytes one at a time. It finds instructions that open with the double escape 0x0F 0x0F. After the escape it reads the addressing bytes: a modR/M byte, an optional SIB byte and zero, one or four displacement bytes. The byte after them is the operation selector. Because that selector is the last byte, its position is known only once the addressing bytes have been decoded. The decoder therefore tracks the addressing rules byte by byte and reports the whole instruction when it ends.

It also handles the short prefetch form 0x0F 0x0D, which has no trailing selector. Its reg field picks a variant: Exclusive, Modified or reserved. Bytes that do not start a recognised instruction are dropped. The block only decodes: it does not handle legacy prefixes, 16-bit addressing or execution.

The byte input is a valid/ready stream. A byte is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low during reset and high at all other times, so the block never pushes back. The upstream side may hold `in_valid` low for any number of cycles, including between the bytes of one instruction. The result side is a plain one-cycle `done` strobe. All result fields are valid in the `done` cycle only.

Top module: `trailop_decoder`

## Requirements
- R1: During reset `in_ready` and `done` are 0. After reset `in_ready` is 1 and `done` stays 0 until an instruction completes.
- R2: `done` is high for exactly one cycle, in the cycle after the edge that accepted the last byte of an instruction. The first byte of the next instruction may be accepted in that same cycle.
- R3: A byte 0x0F, then 0x0F, then addressing bytes, then one more byte is decoded as an escape instruction. On `done`, `opcode` is that final byte, `is_prefetch` is 0 and `length` is 4 + `has_sib` + `disp_len`.
- R4: For a modR/M byte with mod = bits 7:6 equal to 3 (register form), there is no SIB byte and no displacement, even when rm = bits 2:0 equals 4.
- R5: mod = 1 adds one displacement byte. mod = 2 adds four. mod = 0 with rm = 5 adds four.
- R6: mod ≠ 3 with rm = 4 brings in a SIB byte, reported in `sib` with `has_sib` = 1. Then mod = 0 with SIB base (bits 2:0) = 5 adds four displacement bytes.
- R7: Displacement bytes are assembled little-endian into `disp`: the first one goes in bits 7:0, and unused upper bytes are 0. `disp_len` gives their count.
- R8: 0x0F followed by 0x0D is a prefetch. It ends after its addressing bytes. On `done`: `is_prefetch` = 1, `opcode` = 0, `length` = 3 + `has_sib` + `disp_len`.
- R9: `pf_kind` encodes 0 for a non-prefetch, 1 for Exclusive (reg = bits 5:3 equal to 0), 2 for Modified (reg = 1) and 3 for any other reg value (reserved).
- R10: A byte other than 0x0F while idle is dropped. After a first 0x0F, a second byte other than 0x0F or 0x0D is dropped along with it. Neither produces `done`, and the next instruction decodes normally.
- R11: Gaps in `in_valid`, inside or between instructions, do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction byte |
| done | output | 1 | One-cycle strobe: result fields valid |
| is_prefetch | output | 1 | Instruction was the prefetch form |
| pf_kind | output | 2 | Prefetch variant code (R9) |
| opcode | output | 8 | Trailing operation byte (0 for prefetch) |
| modrm | output | 8 | modR/M byte |
| has_sib | output | 1 | SIB byte was present |
| sib | output | 8 | SIB byte (0 if absent) |
| disp | output | 32 | Displacement, little-endian assembled |
| disp_len | output | 3 | Number of displacement bytes (0, 1 or 4) |
| length | output | 4 | Total instruction length in bytes |

## Verification
A wrong addressing state shifts every field that follows it. If the SIB or displacement count is wrong, the decoder takes a displacement byte as the opcode, or the opcode as part of the next instruction. This shows up on the same `done` strobe as a wrong `length` and `opcode`. It also shifts the next instruction, which then yields a spurious or missing `done`. The bench therefore sends instructions back to back and compares every field of every strobe. It also flags any strobe that has no matching expected entry, so a single miscounted byte is caught within one or two instructions.

// File: rtl/trailop_pkg.sv
package trailop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ESC, ST_MODRM, ST_SIB, ST_DISP, ST_OPC
  } dec_state_t;

  localparam logic [1:0] PFK_NONE = 2'd0;
  localparam logic [1:0] PFK_EXCL = 2'd1;
  localparam logic [1:0] PFK_MODF = 2'd2;
  localparam logic [1:0] PFK_RSVD = 2'd3;

  // displacement byte count from mod and the rm (or SIB base) field
  function automatic logic [2:0] disp_bytes(input logic [1:0] md, input logic [2:0] fld);
    logic [2:0] n;
    n = 3'd0;
    if (md == 2'd1) n = 3'd1;
    else if (md == 2'd2) n = 3'd4;
    else if (md == 2'd0 && fld == 3'd5) n = 3'd4;
    return n;
  endfunction
endpackage

// File: rtl/trailop_addr_rules.sv
module trailop_addr_rules
  import trailop_pkg::*;
(
  input  logic       at_sib,
  input  logic [7:0] cur_byte,
  input  logic [1:0] held_mod,
  output logic       need_sib,
  output logic [2:0] disp_n
);
  logic [1:0] md;
  assign md = at_sib ? held_mod : cur_byte[7:6];

  always_comb begin
    need_sib = !at_sib && (md != 2'd3) && (cur_byte[2:0] == 3'd4);
    disp_n   = disp_bytes(md, cur_byte[2:0]);
  end
endmodule

// File: rtl/trailop_disp_pack.sv
module trailop_disp_pack #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  localparam int IW   = $clog2(LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BW-1:0]     byte_in,
  output logic [IW-1:0]     idx,
  output logic [LANES*BW-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (clr)  idx <= '0;
    else if (load) idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        word[g*BW +: BW] <= '0;
      else if (clr)                      word[g*BW +: BW] <= '0;
      else if (load && idx == IW'(g))    word[g*BW +: BW] <= byte_in;
    end
  end
endmodule

// File: rtl/trailop_decoder.sv
module trailop_decoder
  import trailop_pkg::*;
#(
  parameter logic [7:0] ESC_CODE = 8'h0F,
  parameter logic [7:0] PF_CODE  = 8'h0D,
  parameter int DISP_BYTES = 4,
  parameter int LEN_W      = 4,
  localparam int DW = DISP_BYTES * 8,
  localparam int IW = $clog2(DISP_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             done,
  output logic             is_prefetch,
  output logic [1:0]       pf_kind,
  output logic [7:0]       opcode,
  output logic [7:0]       modrm,
  output logic             has_sib,
  output logic [7:0]       sib,
  output logic [DW-1:0]    disp,
  output logic [2:0]       disp_len,
  output logic [LEN_W-1:0] length
);
  dec_state_t st;
  logic       rdy_q, acc, need_sib, pk_clr, pk_load;
  logic [2:0] disp_n;
  logic [IW-1:0] pk_idx;

  assign in_ready = rdy_q;
  assign acc      = in_valid && rdy_q;
  assign pk_clr   = acc && (st == ST_IDLE);
  assign pk_load  = acc && (st == ST_DISP);

  trailop_addr_rules u_rules (
    .at_sib   (st == ST_SIB),
    .cur_byte (in_byte),
    .held_mod (modrm[7:6]),
    .need_sib (need_sib),
    .disp_n   (disp_n)
  );

  trailop_disp_pack #(.LANES(DISP_BYTES), .BW(8)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pk_clr),
    .load    (pk_load),
    .byte_in (in_byte),
    .idx     (pk_idx),
    .word    (disp)
  );

  always_comb begin
    if (!is_prefetch)             pf_kind = PFK_NONE;
    else if (modrm[5:3] == 3'd0)  pf_kind = PFK_EXCL;
    else if (modrm[5:3] == 3'd1)  pf_kind = PFK_MODF;
    else                          pf_kind = PFK_RSVD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rdy_q <= 1'b0; done <= 1'b0; is_prefetch <= 1'b0;
      opcode <= '0; modrm <= '0; has_sib <= 1'b0; sib <= '0;
      disp_len <= '0; length <= '0;
    end else begin
      rdy_q <= 1'b1;
      done  <= 1'b0;
      if (acc) begin
        case (st)
          ST_IDLE: if (in_byte == ESC_CODE) begin
            st <= ST_ESC; length <= LEN_W'(1);
            opcode <= '0; has_sib <= 1'b0; sib <= '0; disp_len <= '0;
          end
          ST_ESC: begin
            length <= length + 1'b1;
            if (in_byte == ESC_CODE)     begin is_prefetch <= 1'b0; st <= ST_MODRM; end
            else if (in_byte == PF_CODE) begin is_prefetch <= 1'b1; st <= ST_MODRM; end
            else st <= ST_IDLE;
          end
          ST_MODRM, ST_SIB: begin
            length <= length + 1'b1;
            if (st == ST_MODRM) modrm <= in_byte;
            else begin sib <= in_byte; has_sib <= 1'b1; end
            if (need_sib)            st <= ST_SIB;
            else if (disp_n != 3'd0) begin st <= ST_DISP; disp_len <= disp_n; end
            else if (is_prefetch)    begin st <= ST_IDLE; done <= 1'b1; end
            else                     st <= ST_OPC;
          end
          ST_DISP: begin
            length <= length + 1'b1;
            if (pk_idx == IW'(disp_len - 3'd1)) begin
              if (is_prefetch) begin st <= ST_IDLE; done <= 1'b1; end
              else st <= ST_OPC;
            end
          end
          ST_OPC: begin
            length <= length + 1'b1;
            opcode <= in_byte;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/trailop_decoder_chk.sv
module trailop_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       done,
  input logic       is_prefetch,
  input logic [1:0] pf_kind,
  input logic [7:0] modrm,
  input logic       has_sib,
  input logic [2:0] disp_len,
  input logic [3:0] length
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_ESC_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_prefetch) |-> length == 4'd4 + 4'(has_sib) + 4'(disp_len)); // R3
  AST_REG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && modrm[7:6] == 2'd3) |-> (!has_sib && disp_len == 3'd0)); // R4
  AST_DISP8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && modrm[7:6] == 2'd1) |-> disp_len == 3'd1); // R5
  AST_SIB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> has_sib == (modrm[7:6] != 2'd3 && modrm[2:0] == 3'd4)); // R6
  AST_PF_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_prefetch) |-> length == 4'd3 + 4'(has_sib) + 4'(disp_len)); // R8
  AST_PF_KIND_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_prefetch) |-> pf_kind == 2'd0); // R9
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R1
endmodule

bind trailop_decoder trailop_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
  .is_prefetch(is_prefetch), .pf_kind(pf_kind), .modrm(modrm),
  .has_sib(has_sib), .disp_len(disp_len), .length(length)
);

// File: tb/sim_trailop_decoder.sv
module sim_trailop_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic in_ready, done, is_prefetch, has_sib;
  logic [7:0] in_byte = 8'h00, opcode, modrm, sib;
  logic [1:0] pf_kind;
  logic [31:0] disp;
  logic [2:0] disp_len;
  logic [3:0] length;

  always #(CLK_PERIOD/2) clk = ~clk;

  trailop_decoder u0 (.*);

  typedef struct packed {
    logic [7:0] opc, mrm, sb; logic hs; logic [31:0] dp;
    logic [2:0] dl; logic [3:0] ln; logic pf; logic [1:0] kind; logic [7:0] tag;
  } exp_t;

  exp_t exq[$];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, int gap);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); in_valid = 1'b0;
    end
    @(negedge clk); in_valid = 1'b1; in_byte = b;
    @(posedge clk);
  endtask

  // pf: prefetch form; hs: SIB present; dl: displacement bytes (computed by test from R4-R6)
  task automatic ins(string req, bit pf, logic [7:0] mrm, bit hs, logic [7:0] sb,
                     int dl, logic [31:0] dp, logic [7:0] opc, int gap);
    exp_t e;
    logic [2:0] rg;
    rg = mrm[5:3];
    e.opc = pf ? 8'h00 : opc; e.mrm = mrm; e.hs = hs; e.sb = hs ? sb : 8'h00;
    e.dl = 3'(dl); e.ln = 4'(2 + 1 + int'(hs) + dl + (pf ? 0 : 1)); e.pf = pf;
    e.kind = !pf ? 2'd0 : (rg == 3'd0) ? 2'd1 : (rg == 3'd1) ? 2'd2 : 2'd3;
    e.dp = 32'h0;
    for (int k = 0; k < dl; k++) e.dp[k*8 +: 8] = dp[k*8 +: 8];
    e.tag = 8'(req.getc(1));
    exq.push_back(e);
    put(8'h0F, gap);
    put(pf ? 8'h0D : 8'h0F, gap);
    put(mrm, gap);
    if (hs) put(sb, gap);
    for (int k = 0; k < dl; k++) put(dp[k*8 +: 8], gap);
    if (!pf) put(opc, gap);
  endtask

  // monitor: scoreboard compare on each strobe
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exq.size() == 0) begin
        chk("R10", 32'(done), 32'h0, "unexpected done");
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk("R3",  32'(opcode),      32'(e.opc),  "opcode");
        chk("R4",  32'(modrm),       32'(e.mrm),  "modrm");
        chk("R6",  32'(has_sib),     32'(e.hs),   "has_sib");
        chk("R6",  32'(sib),         32'(e.sb),   "sib");
        chk("R7",  disp,             e.dp,        "disp");
        chk("R5",  32'(disp_len),    32'(e.dl),   "disp_len");
        chk("R8",  32'(length),      32'(e.ln),   "length");
        chk("R8",  32'(is_prefetch), 32'(e.pf),   "is_prefetch");
        chk("R9",  32'(pf_kind),     32'(e.kind), "pf_kind");
      end
    end
  end

  // R2: done never lasts two cycles
  logic done_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done && done_d) chk("R2", 32'h1, 32'h0, "done held two cycles");
    done_d <= done;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 32'(in_ready), 32'h0, "in_ready in reset");
    chk("R1", 32'(done), 32'h0, "done in reset");
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", 32'(in_ready), 32'h1, "in_ready after reset");
    chk("R1", 32'(done), 32'h0, "done idle");

    ins("R4", 0, 8'hC1, 0, 8'h00, 0, 32'h0, 8'hB4, 0);         // register form
    ins("R5", 0, 8'h40, 0, 8'h00, 1, 32'h12, 8'h9E, 0);        // disp8
    ins("R5", 0, 8'h83, 0, 8'h00, 4, 32'h12345678, 8'hAE, 0);  // disp32 mod2
    ins("R5", 0, 8'h05, 0, 8'h00, 4, 32'hCAFEF00D, 8'h0F, 0);  // mod0 rm5
    ins("R6", 0, 8'h04, 1, 8'h24, 0, 32'h0, 8'h97, 0);         // SIB no disp
    ins("R6", 0, 8'h04, 1, 8'h25, 4, 32'hA1B2C3D4, 8'hB6, 0);  // SIB base5 mod0
    ins("R6", 0, 8'h44, 1, 8'h1D, 1, 32'h80, 8'hA6, 0);        // SIB base5 mod1: disp8
    ins("R4", 0, 8'hC4, 0, 8'h00, 0, 32'h0, 8'h90, 0);         // rm4 register form, no SIB
    ins("R9", 1, 8'h00, 0, 8'h00, 0, 32'h0, 8'h00, 0);         // prefetch Exclusive
    ins("R9", 1, 8'h48, 0, 8'h00, 1, 32'h10, 8'h00, 0);        // prefetch Modified, disp8
    ins("R9", 1, 8'h1C, 1, 8'h25, 4, 32'h00001000, 8'h00, 0);  // reserved, SIB+disp32
    // R10: stray bytes dropped
    put(8'h90, 0); put(8'h0F, 0); put(8'h33, 0);
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", 32'(exq.size()), 32'h0, "queue after garbage");
    ins("R10", 0, 8'h84, 1, 8'h88, 4, 32'h01020304, 8'hBB, 0);
    ins("R11", 0, 8'h4D, 0, 8'h00, 1, 32'hFF, 8'hB0, 2);       // gaps in valid
    ins("R11", 1, 8'h8C, 1, 8'h00, 4, 32'h55AA55AA, 8'h00, 1);
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3", 32'(exq.size()), 32'h0, "results outstanding");
    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule